// File: doc/BRIEF.md
# Per-Bank Access Recovery Guard

This block sits next to a programmable memory-pattern controller. It enforces a minimum idle gap before a memory bank can be accessed again. When the controller runs a pattern word whose timer-start flag is set, it pulses `arm_i` and puts the number of the bank just used on `arm_bank_i`. The guard records that bank and samples the 2-bit gap field. It then counts down the gap in bus clock cycles. While the count runs, it refuses new requests aimed at the recorded bank. Requests to any other bank are accepted at once.

The request side is a valid/ready handshake with the following rules:
- A request is presented with `req_valid_i` and its target bank on `req_bank_i`.
- `req_ready_o` depends only on the target bank and the timer state. It does not depend on `req_valid_i`.
- A request is taken in any cycle where valid and ready are both high. `req_grant_o` marks that cycle.
- A requester that sees ready low must keep its request pending and present it again in a later cycle.
- Ready is combinational, so a refused bank is never granted in the cycle it is refused.

Top module: `bank_guard`

## Requirements
- R1: A gap field value p (binary 00, 01, 10, 11) gives a gap of p+1 bus clocks. After a clock edge where `arm_i` is high, the armed bank sees `req_ready_o` low in exactly the p+1 cycles that follow, and high in the next cycle.
- R2: The timer starts only on a clock edge where `arm_i` is high. With no arm, every bank sees `req_ready_o` high.
- R3: While the timer runs, a request whose bank equals the recorded bank sees `req_ready_o` low and `req_grant_o` low.
- R4: While the timer runs, a request to any other bank sees `req_ready_o` high.
- R5: Once the gap has elapsed, the previously refused bank sees `req_ready_o` high again.
- R6: The gap field is sampled only on the arming edge. Changing `period_i` mid-count does not change the current gap.
- R7: An arm while the timer runs reloads the count from the current gap field and replaces the recorded bank with the new `arm_bank_i`. The old bank is free from the next cycle.
- R8: A synchronous active-high `rst` returns the guard to idle with no bank refused, from the cycle after reset.
- R9: `req_ready_o` is combinational from `req_bank_i` and the timer state. `req_grant_o` equals `req_valid_i` AND `req_ready_o` in the same cycle. The arming cycle itself refuses no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | PER_W (2) | Gap field: value p gives p+1 cycles |
| arm_i | input | 1 | Timer-start flag of the current pattern word |
| arm_bank_i | input | BANK_W (3) | Bank just accessed; recorded on arm |
| req_valid_i | input | 1 | A new access is requested |
| req_bank_i | input | BANK_W (3) | Target bank of the request |
| req_ready_o | output | 1 | Target bank may be accessed this cycle |
| req_grant_o | output | 1 | Request taken this cycle |

## Verification
The hardest situation to reach from the ports is the overlap of two arms: a re-arm that replaces the recorded bank while the old count is still running. Another is a gap-field change that lands mid-count. The stimulus reaches both by sequence:
- It arms one bank and re-arms a different bank on the following edge, with a different gap.
- It flips `period_i` right after each arm.
- It sweeps every request bank in every cycle of the window. This shows the old bank freed at once and the new window sized by the second arm only.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // Gap in cycles for a field value: field + 1.
  function automatic int unsigned gap_cycles(input int unsigned field);
    return field + 1;
  endfunction

  // Counter width able to hold the largest gap for a given field width.
  function automatic int unsigned cnt_width(input int unsigned per_w);
    return per_w + 1;
  endfunction
endpackage

// File: rtl/guard_period_dec.sv
module guard_period_dec #(
  parameter int unsigned PER_W = 2,
  parameter int unsigned CNT_W = guard_pkg::cnt_width(PER_W)
) (
  input  logic [PER_W-1:0] field_i,
  output logic [CNT_W-1:0] load_o
);
  always_comb begin
    load_o = CNT_W'(guard_pkg::gap_cycles(int'(field_i)));
  end
endmodule

// File: rtl/guard_countdown.sv
module guard_countdown #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/guard_bank_cmp.sv
module guard_bank_cmp #(
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture_i,
  input  logic [BANK_W-1:0] cap_bank_i,
  input  logic [BANK_W-1:0] req_bank_i,
  output logic              match_o
);
  logic [BANK_W-1:0] bank_q;
  logic [BANK_W-1:0] bit_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= '0;
    end else if (capture_i) begin
      bank_q <= cap_bank_i;
    end
  end

  for (genvar i = 0; i < BANK_W; i++) begin : g_eq
    assign bit_eq[i] = ~(bank_q[i] ^ req_bank_i[i]);
  end

  assign match_o = &bit_eq;
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned PER_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PER_W-1:0]  period_i,
  input  logic              arm_i,
  input  logic [BANK_W-1:0] arm_bank_i,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  output logic              req_ready_o,
  output logic              req_grant_o
);
  localparam int unsigned CNT_W = guard_pkg::cnt_width(PER_W);

  logic [CNT_W-1:0] load_val;
  logic             busy;
  logic             same_bank;

  guard_period_dec #(.PER_W(PER_W), .CNT_W(CNT_W)) u_dec (
    .field_i (period_i),
    .load_o  (load_val)
  );

  guard_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (arm_i),
    .load_val_i (load_val),
    .busy_o     (busy)
  );

  guard_bank_cmp #(.BANK_W(BANK_W)) u_cmp (
    .clk        (clk),
    .rst        (rst),
    .capture_i  (arm_i),
    .cap_bank_i (arm_bank_i),
    .req_bank_i (req_bank_i),
    .match_o    (same_bank)
  );

  assign req_ready_o = ~(busy & same_bank);
  assign req_grant_o = req_valid_i & req_ready_o;
endmodule

// File: rtl/bank_guard_chk.sv
module bank_guard_chk #(
  parameter int unsigned BANK_W = 3,
  parameter int unsigned PER_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [PER_W-1:0]  period_i,
  input logic              arm_i,
  input logic [BANK_W-1:0] arm_bank_i,
  input logic              req_valid_i,
  input logic [BANK_W-1:0] req_bank_i,
  input logic              req_ready_o,
  input logic              req_grant_o
);
  localparam int unsigned SW = PER_W + 2;

  logic              armed_q;
  logic [SW-1:0]     since_q;
  logic [SW-1:0]     gap_q;
  logic [BANK_W-1:0] bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      since_q <= '0;
      gap_q   <= '0;
      bank_q  <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      since_q <= SW'(1);
      gap_q   <= SW'(period_i) + SW'(1);
      bank_q  <= arm_bank_i;
    end else if (armed_q && since_q <= gap_q) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R3
  same_bank_held_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && since_q <= gap_q && req_bank_i == bank_q) |-> !req_ready_o);

  // R4
  other_bank_free_chk: assert property (@(posedge clk) disable iff (rst)
    (req_bank_i != bank_q) |-> req_ready_o);

  // R5
  expired_free_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && since_q > gap_q) |-> req_ready_o);

  // R8
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> req_ready_o);

  // R9
  grant_gated_chk: assert property (@(posedge clk) disable iff (rst)
    req_grant_o |-> (req_valid_i && req_ready_o));
endmodule

bind bank_guard bank_guard_chk #(.BANK_W(BANK_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/tb_bank_guard.sv
`timescale 1ns/100ps
module tb_bank_guard;
  localparam int BANK_W = 3;
  localparam int PER_W  = 2;
  localparam int NB     = 1 << BANK_W;

  logic              clk = 1'b0;
  logic              rst;
  logic [PER_W-1:0]  period_i;
  logic              arm_i;
  logic [BANK_W-1:0] arm_bank_i;
  logic              req_valid_i;
  logic [BANK_W-1:0] req_bank_i;
  logic              req_ready_o;
  logic              req_grant_o;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  bank_guard #(.BANK_W(BANK_W), .PER_W(PER_W)) dut (.*);

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Sweep all request banks within one cycle; blocked bank = blk when on.
  task automatic check_banks(input bit on, input int blk, input string tag);
    for (int rb = 0; rb < NB; rb++) begin
      req_bank_i = rb[BANK_W-1:0];
      #0.5;
      vectors++;
      if (req_ready_o !== !(on && rb == blk)) begin
        miscompares++;
        $display("FAIL %s: bank %0d ready=%b expected %b", tag, rb, req_ready_o, !(on && rb == blk));
      end
      if (req_grant_o !== (req_valid_i && !(on && rb == blk))) begin
        miscompares++;
        $display("FAIL R9: bank %0d grant=%b expected %b", rb, req_grant_o, req_valid_i && !(on && rb == blk));
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst = 1'b1; period_i = '0; arm_i = 1'b0; arm_bank_i = '0;
    req_valid_i = 1'b1; req_bank_i = '0;
    step(); step();
    rst = 1'b0;
    // R8: idle after reset, R2: no arm means nothing refused
    check_banks(1'b0, 0, "R8");
    step();
    check_banks(1'b0, 0, "R2");

    // R1 R3 R4 R5 R6 R9: every gap value, every armed bank, every request bank
    for (int p = 0; p < 4; p++) begin
      for (int b = 0; b < NB; b++) begin
        period_i = p[PER_W-1:0]; arm_i = 1'b1; arm_bank_i = b[BANK_W-1:0];
        req_valid_i = b[0];
        check_banks(1'b0, b, "R9");
        step();
        arm_i = 1'b0;
        period_i = ~p[PER_W-1:0];
        for (int k = 1; k <= p + 2; k++) begin
          check_banks(k <= p + 1, b, (k <= p + 1) ? "R1" : "R5");
          step();
        end
      end
    end

    // R7: arm bank 2 gap 2, re-arm bank 5 gap 4 on the next edge
    req_valid_i = 1'b1;
    period_i = 2'd1; arm_i = 1'b1; arm_bank_i = 3'd2;
    step();
    check_banks(1'b1, 2, "R7");
    period_i = 2'd3; arm_bank_i = 3'd5;
    step();
    arm_i = 1'b0; period_i = 2'd0;
    for (int k = 1; k <= 5; k++) begin
      check_banks(k <= 4, 5, "R7");
      step();
    end

    // R6: gap field forced to 00 right after a 4-cycle arm
    period_i = 2'd3; arm_i = 1'b1; arm_bank_i = 3'd7;
    step();
    arm_i = 1'b0; period_i = 2'd0;
    for (int k = 1; k <= 5; k++) begin
      check_banks(k <= 4, 7, "R6");
      step();
    end

    // R8: reset in the middle of a count
    period_i = 2'd3; arm_i = 1'b1; arm_bank_i = 3'd4;
    step();
    arm_i = 1'b0;
    check_banks(1'b1, 4, "R3");
    rst = 1'b1;
    step();
    rst = 1'b0;
    check_banks(1'b0, 4, "R8");
    step();

    // R9: no valid means no grant
    req_valid_i = 1'b0;
    check_banks(1'b0, 0, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule